// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is a strictly sequential controller. Each cycle in which it runs, it reads one instruction word from a small writable program store, decodes a 2-bit opcode, and does one of four things. It can issue an operation to an external data path and wait for it to finish. It can jump when a chosen external condition line is high. It can call a subroutine, or return from one. No two control steps overlap, and every step costs at least one program-store access.

The program store is a register array that the surrounding logic (or a testbench) fills through a simple write port, usually while the sequencer is held in reset. After reset, execution begins at address 0. An evoke places an operation code on `op_sel_o`, raises `evoke_o` for one cycle, and parks the sequencer until `done_i` comes back. Return addresses live in a small hardware stack. Misuse of that stack halts the sequencer. Testing a reserved condition code only raises a sticky error.

Top module: `mseq_top`

## Requirements
- R1: While `rst_ni` is low and directly after its release, `pc_o` is 0 and `evoke_o`, `wait_o`, `halt_o` and `err_o` are 0. The first instruction executed is the one at address 0.
- R2: Instruction word layout (15 bits): [14:13] opcode, with 00 evoke, 01 conditional branch, 10 call and 11 return. [12:5] is the target address or evoke code. [4:0] is the condition select.
- R3: A branch that is not taken advances `pc_o` by one on the next clock edge. The increment wraps from 255 to 0.
- R4: An evoke raises `evoke_o` for exactly one cycle, in the cycle after the edge that executes it. In that same cycle it shows the [12:5] field on `op_sel_o`, raises `wait_o` and sets `pc_o` to the next address.
- R5: While `wait_o` is high, no instruction is executed and `pc_o` holds. The edge on which `done_i` is sampled high clears `wait_o`. `done_i` has no effect outside the wait state.
- R6: A conditional branch with select s (0 to 28) loads the target into `pc_o` when `cond_i[s]` is 1. Otherwise it falls through to the next address.
- R7: Select codes 29, 30 and 31 are reserved. A branch using one of them falls through and sets `err_o`, which stays high until reset. The sequencer does not halt.
- R8: A call pushes the address after the call and jumps to the target. A return resumes at the most recently pushed address. Up to 4 calls may be outstanding.
- R9: A call with 4 calls outstanding, or a return with none outstanding, sets `err_o` and `halt_o`. From then until reset, `pc_o` is frozen and no evoke is issued.
- R10: When `prog_we_i` is high, a clock edge writes `prog_data_i` at `prog_addr_i`. This works while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program store write enable |
| prog_addr_i | input | 8 | Program store write address |
| prog_data_i | input | 15 | Program store write data |
| cond_i | input | 29 | External Boolean condition lines |
| done_i | input | 1 | Data-path operation complete |
| evoke_o | output | 1 | One-cycle operation start strobe |
| op_sel_o | output | 8 | Operation code of the last evoke |
| pc_o | output | 8 | Address of the next instruction |
| wait_o | output | 1 | Waiting for `done_i` |
| halt_o | output | 1 | Halted on a stack fault |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench sweeps all 32 condition selects against a set line and a cleared line. It uses a one-hot pattern and its complement, so a mux that picked the wrong line, or treated a reserved code as usable, would branch wrongly or fail to flag the error. It runs the program counter once around its full range, which exposes a missing or early wrap. It holds `done_i` high during the evoke cycle itself, to catch a wait state that releases on a stale pulse. It nests calls to the full stack depth and then pushes one level further, and it also returns with nothing outstanding. A sequencer that overwrote a stack slot, resumed at the wrong address or kept running after the fault would show a different `pc_o` trace.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef enum logic [1:0] {
    OP_EVOKE  = 2'b00,
    OP_BRANCH = 2'b01,
    OP_CALL   = 2'b10,
    OP_RETURN = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_WAIT = 2'b01,
    ST_HALT = 2'b10
  } st_e;
endpackage

// File: rtl/mseq_prog_mem.sv
module mseq_prog_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 15
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // no reset: loadable while the sequencer is held in reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux #(
  parameter int NUM_COND = 29,
  parameter int SEL_W    = 5
) (
  input  logic [NUM_COND-1:0] cond_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                bit_o,
  output logic                rsv_o
);
  localparam int SPACE = 1 << SEL_W;

  logic [SPACE-1:0] padded;

  generate
    if (NUM_COND < SPACE) begin : g_pad
      assign padded = {{(SPACE-NUM_COND){1'b0}}, cond_i};
    end else begin : g_full
      assign padded = cond_i[SPACE-1:0];
    end
  endgenerate

  assign rsv_o = (int'(sel_i) >= NUM_COND);
  assign bit_o = padded[sel_i] & ~rsv_o;
endmodule

// File: rtl/mseq_ret_stack.sv
module mseq_ret_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    slot_q [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] top_idx;

  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign top_idx = sp_q - SP_W'(1);
  assign top_o   = slot_q[top_idx[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (push_i && !full_o) begin
      sp_q <= sp_q + SP_W'(1);
    end else if (pop_i && !empty_o) begin
      sp_q <= sp_q - SP_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) slot_q[sp_q[IDX_W-1:0]] <= din_i;
  end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SEL_W   = 5,
  parameter int INSTR_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               cond_bit_i,
  input  logic               cond_rsv_i,
  input  logic               done_i,
  input  logic               stk_full_i,
  input  logic               stk_empty_i,
  input  logic [ADDR_W-1:0]  stk_top_i,
  output logic               push_o,
  output logic               pop_o,
  output logic [ADDR_W-1:0]  ret_addr_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic               evoke_o,
  output logic [ADDR_W-1:0]  op_sel_o,
  output logic               wait_o,
  output logic               halt_o,
  output logic               err_o
);
  st_e               state_q;
  opc_e              opc;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_inc;
  logic              run;

  assign opc    = opc_e'(instr_i[INSTR_W-1 -: 2]);
  assign tgt    = instr_i[SEL_W +: ADDR_W];
  assign sel_o  = instr_i[SEL_W-1:0];
  assign pc_inc = pc_q + ADDR_W'(1);
  assign run    = (state_q == ST_RUN);

  assign push_o     = run && (opc == OP_CALL) && !stk_full_i;
  assign pop_o      = run && (opc == OP_RETURN) && !stk_empty_i;
  assign ret_addr_o = pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      pc_q     <= '0;
      evoke_o  <= 1'b0;
      op_sel_o <= '0;
      err_o    <= 1'b0;
    end else begin
      evoke_o <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          unique case (opc)
            OP_EVOKE: begin
              evoke_o  <= 1'b1;
              op_sel_o <= tgt;
              pc_q     <= pc_inc;
              state_q  <= ST_WAIT;
            end
            OP_BRANCH: begin
              if (cond_rsv_i) err_o <= 1'b1;
              pc_q <= cond_bit_i ? tgt : pc_inc;
            end
            OP_CALL: begin
              if (stk_full_i) begin
                err_o   <= 1'b1;
                state_q <= ST_HALT;
              end else begin
                pc_q <= tgt;
              end
            end
            OP_RETURN: begin
              if (stk_empty_i) begin
                err_o   <= 1'b1;
                state_q <= ST_HALT;
              end else begin
                pc_q <= stk_top_i;
              end
            end
            default: ;
          endcase
        end
        ST_WAIT: begin
          if (done_i) state_q <= ST_RUN;
        end
        ST_HALT: ;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign pc_o   = pc_q;
  assign wait_o = (state_q == ST_WAIT);
  assign halt_o = (state_q == ST_HALT);
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SEL_W       = 5,
  parameter int NUM_COND    = 29,
  parameter int STACK_DEPTH = 4,
  localparam int INSTR_W    = 2 + ADDR_W + SEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_we_i,
  input  logic [ADDR_W-1:0]   prog_addr_i,
  input  logic [INSTR_W-1:0]  prog_data_i,
  input  logic [NUM_COND-1:0] cond_i,
  input  logic                done_i,
  output logic                evoke_o,
  output logic [ADDR_W-1:0]   op_sel_o,
  output logic [ADDR_W-1:0]   pc_o,
  output logic                wait_o,
  output logic                halt_o,
  output logic                err_o
);
  logic [INSTR_W-1:0] instr;
  logic [SEL_W-1:0]   sel;
  logic               cond_bit, cond_rsv;
  logic               push, pop, stk_full, stk_empty;
  logic [ADDR_W-1:0]  stk_top, ret_addr;

  mseq_prog_mem #(.ADDR_W(ADDR_W), .DATA_W(INSTR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (prog_we_i),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc_o),
    .rdata_o (instr)
  );

  mseq_cond_mux #(.NUM_COND(NUM_COND), .SEL_W(SEL_W)) u_cmux (
    .cond_i (cond_i),
    .sel_i  (sel),
    .bit_o  (cond_bit),
    .rsv_o  (cond_rsv)
  );

  mseq_ret_stack #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (ret_addr),
    .top_o   (stk_top),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  mseq_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .INSTR_W(INSTR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .instr_i     (instr),
    .cond_bit_i  (cond_bit),
    .cond_rsv_i  (cond_rsv),
    .done_i      (done_i),
    .stk_full_i  (stk_full),
    .stk_empty_i (stk_empty),
    .stk_top_i   (stk_top),
    .push_o      (push),
    .pop_o       (pop),
    .ret_addr_o  (ret_addr),
    .sel_o       (sel),
    .pc_o        (pc_o),
    .evoke_o     (evoke_o),
    .op_sel_o    (op_sel_o),
    .wait_o      (wait_o),
    .halt_o      (halt_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic              evoke_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              wait_o,
  input logic              halt_o,
  input logic              err_o
);
  AST_EVOKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evoke_o |=> !evoke_o); // R4
  AST_EVOKE_ENTERS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evoke_o |-> wait_o); // R4
  AST_WAIT_HOLDS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && !done_i) |=> (wait_o && $stable(pc_o))); // R5
  AST_WAIT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && done_i) |=> !wait_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && $stable(pc_o) && !evoke_o)); // R9
  AST_HALT_HAS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> err_o); // R9
endmodule

bind mseq_top mseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_i  (done_i),
  .evoke_o (evoke_o),
  .pc_o    (pc_o),
  .wait_o  (wait_o),
  .halt_o  (halt_o),
  .err_o   (err_o)
);

// File: tb/tb_mseq_top.sv
module tb_mseq_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] EVK = 2'b00, BRN = 2'b01, CAL = 2'b10, RET = 2'b11;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [7:0]  prog_addr_i = '0;
  logic [14:0] prog_data_i = '0;
  logic [28:0] cond_i = '0;
  logic        done_i = 1'b0;
  logic        evoke_o, wait_o, halt_o, err_o;
  logic [7:0]  op_sel_o, pc_o;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mseq_top dut (.*);

  function automatic logic [14:0] mk(logic [1:0] op, logic [7:0] tgt, logic [4:0] sel);
    return {op, tgt, sel};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [14:0] d);
    @(negedge clk_i);
    prog_we_i = 1'b1; prog_addr_i = a; prog_data_i = d;
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1 / R10: load during reset, check reset state
    hold_reset();
    wr(8'h00, mk(BRN, 8'h40, 5'd0));
    chk("R1 pc", pc_o, 0);
    chk("R1 evoke", evoke_o, 0);
    chk("R1 wait", wait_o, 0);
    chk("R1 halt", halt_o, 0);
    chk("R1 err", err_o, 0);

    // R6 / R7: sweep every select code, line set and line cleared
    for (int s = 0; s < 32; s++) begin
      for (int v = 0; v < 2; v++) begin
        hold_reset();
        wr(8'h00, mk(BRN, 8'h40, 5'(s)));
        if (s < 29) cond_i = v ? (29'd1 << s) : ~(29'd1 << s);
        else        cond_i = '1;
        rst_ni = 1'b1;
        chk("R1 pc after release", pc_o, 0);
        step();
        chk((s < 29) ? "R6 branch target" : "R7 reserved fallthrough",
            pc_o, (s < 29 && v == 1) ? 8'h40 : 8'h01);
        chk("R7 err flag", err_o, (s >= 29) ? 1 : 0);
        chk("R7 no halt", halt_o, 0);
      end
    end

    // R3: full-range sequential walk with wrap
    hold_reset();
    for (int a = 0; a < 256; a++) wr(8'(a), mk(BRN, 8'h00, 5'd0));
    cond_i = '0;
    rst_ni = 1'b1;
    for (int k = 1; k <= 260; k++) begin
      step();
      chk("R3 sequential pc", pc_o, k % 256);
    end

    // R4 / R5: evoke and wait, stale done ignored
    hold_reset();
    wr(8'h00, mk(EVK, 8'hA5, 5'd0));
    wr(8'h01, mk(EVK, 8'h3C, 5'd0));
    wr(8'h02, mk(BRN, 8'h02, 5'd1));
    cond_i = 29'd2;
    done_i = 1'b1;
    rst_ni = 1'b1;
    step();
    done_i = 1'b0;
    chk("R4 evoke pulse", evoke_o, 1);
    chk("R4 op_sel", op_sel_o, 8'hA5);
    chk("R4 wait", wait_o, 1);
    chk("R4 pc next", pc_o, 1);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R4 single pulse", evoke_o, 0);
      chk("R5 wait held", wait_o, 1);
      chk("R5 pc held", pc_o, 1);
    end
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    chk("R5 released", wait_o, 0);
    chk("R5 pc after release", pc_o, 1);
    step();
    chk("R4 second evoke", evoke_o, 1);
    chk("R4 second op_sel", op_sel_o, 8'h3C);
    chk("R4 second pc", pc_o, 2);
    done_i = 1'b1;
    step();
    step();
    done_i = 1'b0;
    chk("R6 self loop", pc_o, 2);
    chk("R5 running", wait_o, 0);

    // R8: nest to full depth and unwind
    hold_reset();
    wr(8'h00, mk(CAL, 8'h10, 5'd0));
    wr(8'h01, mk(BRN, 8'h01, 5'd1));
    wr(8'h10, mk(CAL, 8'h20, 5'd0));
    wr(8'h11, mk(RET, 8'h00, 5'd0));
    wr(8'h20, mk(CAL, 8'h30, 5'd0));
    wr(8'h21, mk(RET, 8'h00, 5'd0));
    wr(8'h30, mk(CAL, 8'h40, 5'd0));
    wr(8'h31, mk(RET, 8'h00, 5'd0));
    wr(8'h40, mk(RET, 8'h00, 5'd0));
    cond_i = 29'd2;
    rst_ni = 1'b1;
    begin
      logic [7:0] trace [9] = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h31,
                                8'h21, 8'h11, 8'h01, 8'h01};
      for (int k = 0; k < 9; k++) begin
        step();
        chk("R8 call/return trace", pc_o, trace[k]);
      end
    end
    chk("R8 no err", err_o, 0);

    // R9: overflow on fifth call
    hold_reset();
    wr(8'h40, mk(CAL, 8'h50, 5'd0));
    wr(8'h50, mk(EVK, 8'h77, 5'd0));
    rst_ni = 1'b1;
    for (int k = 0; k < 5; k++) step();
    chk("R9 overflow halt", halt_o, 1);
    chk("R9 overflow err", err_o, 1);
    chk("R9 overflow pc", pc_o, 8'h40);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R9 frozen pc", pc_o, 8'h40);
      chk("R9 no evoke", evoke_o, 0);
      chk("R9 err sticky", err_o, 1);
    end

    // R9: underflow on return with empty stack
    hold_reset();
    wr(8'h00, mk(RET, 8'h00, 5'd0));
    rst_ni = 1'b1;
    step();
    chk("R9 underflow halt", halt_o, 1);
    chk("R9 underflow err", err_o, 1);
    chk("R9 underflow pc", pc_o, 0);

    // R2: opcode field decode, one word of each kind back to back
    hold_reset();
    wr(8'h00, mk(BRN, 8'h05, 5'd28));
    wr(8'h05, mk(CAL, 8'h09, 5'd0));
    wr(8'h09, mk(RET, 8'h00, 5'd0));
    wr(8'h06, mk(EVK, 8'hC3, 5'd0));
    cond_i = 29'd1 << 28;
    rst_ni = 1'b1;
    step(); chk("R2 branch opcode", pc_o, 8'h05);
    step(); chk("R2 call opcode", pc_o, 8'h09);
    step(); chk("R2 return opcode", pc_o, 8'h06);
    step(); chk("R2 evoke opcode", op_sel_o, 8'hC3);
    chk("R2 evoke strobe", evoke_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule